// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

The block holds two timer/counter channels. Each channel has an 8-bit low byte and an 8-bit high byte. A 3-bit mode code per channel selects how the two bytes advance:

- a 13-bit count, in which five bits of the low byte act as a prescaler beneath the high byte;
- a 16-bit cascaded count;
- an 8-bit count that reloads itself from the high byte;
- a split arrangement that turns channel 0 into two independent 8-bit counters.

Each channel has a run bit, a gate-enable bit and a source select. The source select picks between counting system clock cycles and counting falling edges on an external event pin. Each channel also has an external gate pin, which lets software measure the width of a pulse.

Software writes either byte of either channel through a shared data bus with per-byte strobes. All four bytes can be read at all times. An overflow sets a per-channel flag, which stays set until software pulses the matching clear input. The block has no data stream, so every pin is a plain level or a one-cycle strobe and no back-pressure applies.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all four count bytes read 0x00 and both flags read 0.
- R2: A channel advances only while its run bit is 1 and either its gate-enable bit is 0 or its gate pin is high. The gate pin passes through a two-flop synchroniser before use.
- R3: Mode code 001 counts {high,low} as one 16-bit value. A step from 0xFFFF to 0x0000 sets the channel flag.
- R4: Mode code 000 counts a 13-bit value formed from the high byte (upper part) and low-byte bits [4:0]. Low-byte bits [7:5] keep their written value. A step from all ones to zero sets the flag.
- R5: Mode code 010 counts the low byte alone. When the low byte steps past 0xFF, it loads the high byte's value and the flag is set. The high byte never changes in this mode.
- R6: With channel 0 at code 011, channel 0's low byte is an 8-bit counter that uses channel 0's run, gate and source controls and sets flag 0. Channel 0's high byte counts every clock while channel 1's run bit is 1. The high byte's wrap from 0xFF to 0x00 sets flag 1, and channel 1's own overflows then set no flag.
- R7: A channel 1 set to code 011 holds both of its bytes.
- R8: With source select 0, a channel counts clock cycles. With source select 1, it counts falling edges of its event pin after a two-flop synchroniser. It adds at most one per clock, and a steady pin adds nothing.
- R9: Codes 100, 101, 110 and 111 hold the channel's bytes and never set its flag.
- R10: A byte write takes effect in the next cycle and overrides any count step in that cycle. Outside split mode, a write to either byte suppresses that channel's step in the same cycle.
- R11: A flag remains set until a one-cycle pulse on its clear input. If an overflow and a clear fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode0 | input | 3 | Mode code, channel 0 |
| mode1 | input | 3 | Mode code, channel 1 |
| run | input | 2 | Run bit per channel |
| gate_en | input | 2 | Gate-enable bit per channel |
| evt_sel | input | 2 | Source select per channel (1 = event pin) |
| evt_pin | input | 2 | External event pin per channel |
| gate_pin | input | 2 | External gate pin per channel |
| wr_lo | input | 2 | Write strobe, low byte, per channel |
| wr_hi | input | 2 | Write strobe, high byte, per channel |
| wr_data | input | 8 | Write data |
| flag_clr | input | 2 | Flag clear pulse per channel |
| lo0 | output | 8 | Channel 0 low byte |
| hi0 | output | 8 | Channel 0 high byte |
| lo1 | output | 8 | Channel 1 low byte |
| hi1 | output | 8 | Channel 1 high byte |
| flag | output | 2 | Overflow flag per channel |

## Verification
The assertions assume that the mode code, run bit and write strobes of a channel are steady around each clock edge. They also assume that a byte is written only through its strobe, so that any unexpected change in a held byte can be blamed on the counting logic. The stimulus changes every control input at the falling edge of the clock. Before the bench relies on a gate or event level, it waits out the synchroniser's delay with run low. The bench changes mode codes only while the run bits are low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef logic [2:0] tmode_t;
  localparam tmode_t MODE_PRE13   = 3'b000;
  localparam tmode_t MODE_CAS16   = 3'b001;
  localparam tmode_t MODE_RELOAD8 = 3'b010;
  localparam tmode_t MODE_SPLIT   = 3'b011;
endpackage

// File: rtl/tmr_sync.sv
// Synchroniser for an external pin; EDGE selects level or falling-edge output.
module tmr_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int DEPTH = EDGE ? STAGES + 1 : STAGES;

  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[DEPTH-2:0], d};
  end

  generate
    if (EDGE) begin : g_fall
      assign q = sr[DEPTH-1] & ~sr[DEPTH-2];
    end else begin : g_level
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/tmr_chan.sv
// One channel's byte pair and its per-mode next-state logic.
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5,
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_t            mode,
  input  logic              tick,
  input  logic              hi_tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf,
  output logic              hi_ovf
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic              any_wr;

  assign any_wr = wr_lo | wr_hi;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    ovf    = 1'b0;
    hi_ovf = 1'b0;
    case (mode)
      MODE_PRE13: begin
        if (tick && !any_wr) begin
          lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_W'(1);
          if (&lo_q[PRE_W-1:0]) begin
            hi_n = hi_q + BYTE_W'(1);
            ovf  = &hi_q;
          end
        end
      end
      MODE_CAS16: begin
        if (tick && !any_wr) begin
          {hi_n, lo_n} = {hi_q, lo_q} + WIDE_W'(1);
          ovf          = &{hi_q, lo_q};
        end
      end
      MODE_RELOAD8: begin
        if (tick && !any_wr) begin
          if (&lo_q) begin
            lo_n = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_n = lo_q + BYTE_W'(1);
          end
        end
      end
      MODE_SPLIT: begin
        if (HAS_SPLIT) begin
          if (tick && !wr_lo) begin
            lo_n = lo_q + BYTE_W'(1);
            ovf  = &lo_q;
          end
          if (hi_tick && !wr_hi) begin
            hi_n   = hi_q + BYTE_W'(1);
            hi_ovf = &hi_q;
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
// Two timer/counter channels with shared write bus and split-mode routing.
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode0,
  input  logic [2:0]        mode1,
  input  logic [1:0]        run,
  input  logic [1:0]        gate_en,
  input  logic [1:0]        evt_sel,
  input  logic [1:0]        evt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        wr_lo,
  input  logic [1:0]        wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        flag_clr,
  output logic [BYTE_W-1:0] lo0,
  output logic [BYTE_W-1:0] hi0,
  output logic [BYTE_W-1:0] lo1,
  output logic [BYTE_W-1:0] hi1,
  output logic [1:0]        flag
);
  localparam int NCH = 2;

  tmode_t [NCH-1:0]             mode_v;
  logic   [NCH-1:0]             gate_lvl, evt_fall, enable, tick, hi_tick;
  logic   [NCH-1:0]             ovf, hi_ovf, flag_set;
  logic   [NCH-1:0][BYTE_W-1:0] lo_v, hi_v;
  logic                         split0;

  assign mode_v[0] = mode0;
  assign mode_v[1] = mode1;
  assign split0    = (mode0 == MODE_SPLIT);

  // The split high byte is driven by channel 1's run bit alone.
  assign hi_tick[0] = run[1];
  assign hi_tick[1] = 1'b0;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      tmr_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) i_gate_sync (
        .clk(clk), .rst_n(rst_n), .d(gate_pin[c]), .q(gate_lvl[c]));
      tmr_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) i_evt_sync (
        .clk(clk), .rst_n(rst_n), .d(evt_pin[c]), .q(evt_fall[c]));

      assign enable[c] = run[c] & (~gate_en[c] | gate_lvl[c]);
      assign tick[c]   = enable[c] & (evt_sel[c] ? evt_fall[c] : 1'b1);

      tmr_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .HAS_SPLIT(c == 0)) i_chan (
        .clk(clk), .rst_n(rst_n), .mode(mode_v[c]), .tick(tick[c]),
        .hi_tick(hi_tick[c]), .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]),
        .wr_data(wr_data), .lo_q(lo_v[c]), .hi_q(hi_v[c]),
        .ovf(ovf[c]), .hi_ovf(hi_ovf[c]));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag[c] <= 1'b0;
        else        flag[c] <= flag_set[c] | (flag[c] & ~flag_clr[c]);
      end
    end
  endgenerate

  // In split mode, channel 1's flag belongs to channel 0's high byte.
  assign flag_set[0] = ovf[0];
  assign flag_set[1] = split0 ? hi_ovf[0] : ovf[1];

  assign lo0 = lo_v[0];
  assign hi0 = hi_v[0];
  assign lo1 = lo_v[1];
  assign hi1 = hi_v[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode0,
  input logic [2:0] mode1,
  input logic [1:0] run,
  input logic [1:0] wr_lo,
  input logic [1:0] wr_hi,
  input logic [7:0] wr_data,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic [1:0] flag
);
  // R2: channel 0 stopped and not written means nothing moves
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !wr_lo[0] && !wr_hi[0] && mode0 != 3'b011) |=> ($stable(lo0) && $stable(hi0)));

  assert_pre13_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 3'b000 && !wr_lo[0]) |=> $stable(lo0[7:5]));

  assert_reload_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 3'b010 && !wr_hi[0]) |=> $stable(hi0));

  assert_ch1_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 == 3'b011 && !wr_lo[1] && !wr_hi[1]) |=> ($stable(lo1) && $stable(hi1)));

  assert_reserved_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0[2] && !wr_lo[0] && !wr_hi[0]) |=> ($stable(lo0) && $stable(hi0)));

  assert_reserved_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0[2] && !flag[0]) |=> !flag[0]);

  assert_write_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo[0] |=> (lo0 == $past(wr_data)));

  assert_write_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi[1] |=> (hi1 == $past(wr_data)));
endmodule

bind tmr_pair tmr_pair_chk i_chk (.*);

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode0 = 3'b001, mode1 = 3'b001;
  logic [1:0] run = '0, gate_en = '0, evt_sel = '0, evt_pin = '0, gate_pin = '0;
  logic [1:0] wr_lo = '0, wr_hi = '0, flag_clr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] lo0, hi0, lo1, hi1;
  logic [1:0] flag;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  tmr_pair i_tmr_pair (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_lo(input int ch, input logic [7:0] v);
    wr_lo[ch] = 1'b1; wr_data = v;
    idle(1);
    wr_lo[ch] = 1'b0;
  endtask

  task automatic write_hi(input int ch, input logic [7:0] v);
    wr_hi[ch] = 1'b1; wr_data = v;
    idle(1);
    wr_hi[ch] = 1'b0;
  endtask

  task automatic run_for(input int ch, input int n);
    run[ch] = 1'b1;
    idle(n);
    run[ch] = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 2'b11;
    idle(1);
    flag_clr = 2'b00;
  endtask

  task automatic t_reset();
    chk_eq("R1 lo0", lo0, 0); chk_eq("R1 hi0", hi0, 0);
    chk_eq("R1 lo1", lo1, 0); chk_eq("R1 hi1", hi1, 0);
    chk_eq("R1 flag", flag, 0);
  endtask

  task automatic t_cas16();
    mode0 = 3'b001;
    write_lo(0, 8'hFE); write_hi(0, 8'hFF);
    run_for(0, 1);
    chk_eq("R3 count FFFF", {hi0, lo0}, 16'hFFFF);
    chk_eq("R3 no flag yet", flag[0], 0);
    run_for(0, 1);
    chk_eq("R3 wrap", {hi0, lo0}, 16'h0000);
    chk_eq("R3 flag set", flag[0], 1);
    idle(3);
    chk_eq("R11 flag sticky", flag[0], 1);
    flag_clr[0] = 1'b1; idle(1); flag_clr[0] = 1'b0;
    chk_eq("R11 flag cleared", flag[0], 0);
    write_lo(0, 8'hFF); write_hi(0, 8'hFF);
    run[0] = 1'b1; flag_clr[0] = 1'b1;
    idle(1);
    run[0] = 1'b0; flag_clr[0] = 1'b0;
    chk_eq("R11 set beats clear", flag[0], 1);
    clear_flags();
  endtask

  task automatic t_pre13();
    mode0 = 3'b000;
    write_lo(0, 8'hFE); write_hi(0, 8'h00);
    run_for(0, 3);
    chk_eq("R4 low byte", lo0, 8'hE1);
    chk_eq("R4 carry into high", hi0, 8'h01);
    chk_eq("R4 no flag", flag[0], 0);
    write_lo(0, 8'hFF); write_hi(0, 8'hFF);
    run_for(0, 1);
    chk_eq("R4 wrap low", lo0, 8'hE0);
    chk_eq("R4 wrap high", hi0, 8'h00);
    chk_eq("R4 flag", flag[0], 1);
    clear_flags();
  endtask

  task automatic t_reload();
    mode0 = 3'b010;
    write_hi(0, 8'h80); write_lo(0, 8'hFE);
    run_for(0, 1);
    chk_eq("R5 step", lo0, 8'hFF);
    run_for(0, 1);
    chk_eq("R5 reload", lo0, 8'h80);
    chk_eq("R5 flag", flag[0], 1);
    run_for(0, 1);
    chk_eq("R5 after reload", lo0, 8'h81);
    chk_eq("R5 high kept", hi0, 8'h80);
    clear_flags();
  endtask

  task automatic t_gate();
    mode0 = 3'b001;
    write_lo(0, 8'h00); write_hi(0, 8'h00);
    gate_en[0] = 1'b1; gate_pin[0] = 1'b0;
    idle(3);
    run_for(0, 10);
    chk_eq("R2 gate low blocks", lo0, 0);
    gate_pin[0] = 1'b1;
    idle(3);
    run_for(0, 5);
    chk_eq("R2 gate high counts", lo0, 5);
    gate_en[0] = 1'b0; gate_pin[0] = 1'b0;
    idle(3);
    run_for(0, 4);
    chk_eq("R2 gate disabled counts", lo0, 9);
  endtask

  task automatic t_counter();
    mode1 = 3'b001; evt_sel[1] = 1'b1; evt_pin[1] = 1'b0;
    write_lo(1, 8'h00); write_hi(1, 8'h00);
    idle(3);
    run[1] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      evt_pin[1] = 1'b1; idle(3);
      evt_pin[1] = 1'b0; idle(3);
    end
    idle(3);
    chk_eq("R8 four falling edges", lo1, 4);
    evt_pin[1] = 1'b1; idle(20);
    chk_eq("R8 steady pin", lo1, 4);
    evt_pin[1] = 1'b0; idle(5);
    chk_eq("R8 one more edge", lo1, 5);
    run[1] = 1'b0; evt_sel[1] = 1'b0;
    run_for(1, 3);
    chk_eq("R8 clock source", lo1, 8);
  endtask

  task automatic t_split();
    mode0 = 3'b011; mode1 = 3'b011;
    write_lo(0, 8'hFE); write_hi(0, 8'hFF);
    write_lo(1, 8'h33); write_hi(1, 8'h44);
    run = 2'b11;
    idle(2);
    run = 2'b00;
    chk_eq("R6 split low wrap", lo0, 8'h00);
    chk_eq("R6 flag0 from low", flag[0], 1);
    chk_eq("R6 split high", hi0, 8'h01);
    chk_eq("R6 flag1 from high", flag[1], 1);
    chk_eq("R7 ch1 low held", lo1, 8'h33);
    chk_eq("R7 ch1 high held", hi1, 8'h44);
    clear_flags();
    run_for(1, 3);
    chk_eq("R6 high uses run1", hi0, 8'h04);
    chk_eq("R6 low idle", lo0, 8'h00);
    mode1 = 3'b001;
    write_lo(1, 8'hFF); write_hi(1, 8'hFF);
    run[1] = 1'b1; idle(1); run[1] = 1'b0;
    chk_eq("R6 ch1 overflow masked", flag[1], 0);
    mode0 = 3'b001;
    clear_flags();
  endtask

  task automatic t_reserved();
    for (int m = 4; m < 8; m++) begin
      mode0 = 3'(m);
      write_lo(0, 8'hFF); write_hi(0, 8'hFF);
      run_for(0, 4);
      chk_eq("R9 held", {hi0, lo0}, 16'hFFFF);
      chk_eq("R9 no flag", flag[0], 0);
    end
    mode0 = 3'b001;
  endtask

  task automatic t_wrprio();
    mode0 = 3'b001;
    write_lo(0, 8'h00); write_hi(0, 8'h00);
    run[0] = 1'b1;
    idle(3);
    wr_lo[0] = 1'b1; wr_data = 8'h40;
    idle(1);
    wr_lo[0] = 1'b0; run[0] = 1'b0;
    chk_eq("R10 write wins", lo0, 8'h40);
    chk_eq("R10 high untouched", hi0, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_cas16();
    t_pre13();
    t_reload();
    t_gate();
    t_counter();
    t_split();
    t_reserved();
    t_wrprio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule